// File: doc/BRIEF.md
# Comma-Based Code Group Aligner

This block sits right after a deserializer. It takes a raw bit stream, `IN_W` bits per clock, and turns it into 10-bit 8B/10B code groups. The bits in each input word are ordered earliest first, with bit 0 the oldest. A gearbox packs them into 10-bit raw words. Each raw word is joined with the previous one into a 20-bit window, and all ten possible group boundaries in that window are checked for a comma in the same cycle.

Lock needs repeated evidence. The aligner counts error-free commas at one candidate boundary and locks only when four have been seen there. Once locked, it forwards each group cut at the locked boundary together with a valid strobe. A run of four consecutive invalid groups drops the lock and raises the not-synchronized flag, and the search then starts again.

A per-word mode input selects bypass instead. In bypass, every ten bits are forwarded exactly as they were received, with no search at all. 8B/10B decoding, clock recovery and disparity tracking are left to other blocks.

Top module: `comma_aligner`

## Requirements
- R1: After reset, `grp_v_o` is 0 and `nsync_o` is 1.
- R2: A candidate group is the ten bits starting at some offset, with group bit i equal to the i-th bit received. It is a comma when its bits 0..7 read 0,0,1,1,1,1,1,0 or 1,1,0,0,0,0,0,1. On `grp_o`, bit i carries group bit i.
- R3: Lock is reached on the fourth error-free comma counted at one offset. The group that completes the count is the first one forwarded.
- R4: A valid non-comma group at the candidate offset leaves the count unchanged. Commas of either polarity count alike.
- R5: A comma found at an offset other than the current candidate makes that offset the new candidate, with the count restarted at one.
- R6: While not locked in align mode, `nsync_o` is 1 and no group is forwarded.
- R7: A group is invalid when its count of ones lies outside 4..6. This includes a comma pattern with a bad count, which is not counted as a comma. An invalid group at the candidate offset during search clears the count.
- R8: Once locked, a group is forwarded for every word, including invalid ones. A valid group resets the invalid run. The fourth consecutive invalid group is not forwarded, `nsync_o` rises, and search restarts. Commas at other offsets are ignored while locked.
- R9: In bypass (`align_en_i` = 0), each raw word is forwarded unchanged with `grp_v_o` = 1 and `nsync_o` = 1.
- R10: The mode is sampled together with the last bits of each raw word. A bypass word clears both the lock and the search count.
- R11: With `IN_W` = 10, the group for the word presented in cycle t appears on the outputs after the clock edge that ends cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| align_en_i | input | 1 | 1: comma search and alignment; 0: bypass packing |
| din_i | input | IN_W | Raw bits, bit 0 received first |
| grp_o | output | 10 | Code group, bit 0 first in time |
| grp_v_o | output | 1 | Group valid strobe |
| nsync_o | output | 1 | Not byte-synchronized flag |

## Verification
Directed streams place commas at fixed bit skews, so that each lock point can be worked out by hand. These streams separate five behaviours: counting to four across interleaved data and mixed-polarity commas, a restart caused by an offset jump, clearing caused by a bad-weight comma, the difference between three and four invalid groups after lock, and the clearing effect of a bypass word. A bypass stream full of commas shows that no search happens in that mode. A long random mix of commas, data, invalid groups, bit slips and mode flips is compared word by word, in the exact cycle, against a bench model of the requirements.

// File: rtl/cga_pkg.sv
package cga_pkg;
   localparam int CG_W     = 10;
   localparam int OFF_W    = $clog2(CG_W);
   localparam int MIN_ONES = 4;
   localparam int MAX_ONES = 6;
   // bits 0..7 of a comma, written MSB first (bit 7 left)
   localparam logic [7:0] PAT_LO = 8'b0111_1100;
   localparam logic [7:0] PAT_HI = 8'b1000_0011;

   function automatic logic [3:0] pop_cg(input logic [CG_W-1:0] g);
      pop_cg = '0;
      for (int i = 0; i < CG_W; i++) pop_cg = pop_cg + {3'b000, g[i]};
   endfunction
endpackage

// File: rtl/cga_gear.sv
module cga_gear
   import cga_pkg::*;
#(
   parameter int IN_W = 10
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            align_en_i,
   input  logic [IN_W-1:0] din_i,
   output logic [CG_W-1:0] raw_q,
   output logic            raw_v,
   output logic            raw_align
);
   localparam int CYC = CG_W / IN_W;

   if (CG_W % IN_W != 0) begin : g_bad_width
      $error("IN_W must divide the code group width");
   end

   if (CYC == 1) begin : g_direct
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            raw_q     <= '0;
            raw_v     <= 1'b0;
            raw_align <= 1'b0;
         end else begin
            raw_q     <= din_i;
            raw_v     <= 1'b1;
            raw_align <= align_en_i;
         end
      end
   end else begin : g_pack
      localparam int AW  = (CYC - 1) * IN_W;
      localparam int CW  = $clog2(CYC);
      logic [AW-1:0] acc;
      logic [CW-1:0] phase;
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            acc       <= '0;
            phase     <= '0;
            raw_q     <= '0;
            raw_v     <= 1'b0;
            raw_align <= 1'b0;
         end else if (phase == CW'(CYC - 1)) begin
            raw_q     <= {din_i, acc};
            raw_v     <= 1'b1;
            raw_align <= align_en_i;
            phase     <= '0;
         end else begin
            acc   <= (acc >> IN_W) | (AW'(din_i) << ((CYC - 2) * IN_W));
            raw_v <= 1'b0;
            phase <= phase + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cga_scan.sv
module cga_scan
   import cga_pkg::*;
(
   input  logic [2*CG_W-1:0] win,
   output logic [CG_W-1:0]   hit,
   output logic [CG_W-1:0]   good,
   output logic              any_hit,
   output logic [OFF_W-1:0]  first_off
);
   for (genvar o = 0; o < CG_W; o++) begin : g_off
      logic [CG_W-1:0] cand;
      logic [3:0]      ones;
      assign cand    = win[o +: CG_W];
      assign ones    = pop_cg(cand);
      assign good[o] = (ones >= 4'(MIN_ONES)) && (ones <= 4'(MAX_ONES));
      assign hit[o]  = good[o] && ((cand[7:0] == PAT_LO) || (cand[7:0] == PAT_HI));
   end

   assign any_hit = |hit;

   always_comb begin
      first_off = '0;
      for (int i = CG_W - 1; i >= 0; i--) begin
         if (hit[i]) first_off = OFF_W'(i);
      end
   end
endmodule

// File: rtl/cga_lock.sv
module cga_lock
   import cga_pkg::*;
#(
   parameter int LOCK_N = 4,
   parameter int LOSS_N = 4,
   localparam int CNT_W = $clog2(LOCK_N + 1),
   localparam int BAD_W = $clog2(LOSS_N + 1)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             step,
   input  logic             align,
   input  logic [CG_W-1:0]  hit,
   input  logic [CG_W-1:0]  good,
   input  logic             any_hit,
   input  logic [OFF_W-1:0] first_off,
   output logic             locked_q,
   output logic [OFF_W-1:0] off_q,
   output logic             lock_nx,
   output logic [OFF_W-1:0] off_nx,
   output logic [CNT_W-1:0] cnt_q,
   output logic [BAD_W-1:0] bad_q
);
   logic [CNT_W-1:0] cnt_nx;
   logic [BAD_W-1:0] bad_nx;

   always_comb begin
      lock_nx = locked_q;
      off_nx  = off_q;
      cnt_nx  = cnt_q;
      bad_nx  = bad_q;
      if (step) begin
         if (!align) begin
            lock_nx = 1'b0;
            off_nx  = '0;
            cnt_nx  = '0;
            bad_nx  = '0;
         end else if (!locked_q) begin
            if (cnt_q != '0 && hit[off_q]) begin
               if (cnt_q == CNT_W'(LOCK_N - 1)) begin
                  lock_nx = 1'b1;
                  cnt_nx  = '0;
                  bad_nx  = '0;
               end else begin
                  cnt_nx = cnt_q + 1'b1;
               end
            end else if (any_hit) begin
               off_nx = first_off;
               cnt_nx = CNT_W'(1);
            end else if (cnt_q != '0 && !good[off_q]) begin
               cnt_nx = '0;
            end
         end else if (!good[off_q]) begin
            if (bad_q == BAD_W'(LOSS_N - 1)) begin
               lock_nx = 1'b0;
               bad_nx  = '0;
            end else begin
               bad_nx = bad_q + 1'b1;
            end
         end else begin
            bad_nx = '0;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         locked_q <= 1'b0;
         off_q    <= '0;
         cnt_q    <= '0;
         bad_q    <= '0;
      end else begin
         locked_q <= lock_nx;
         off_q    <= off_nx;
         cnt_q    <= cnt_nx;
         bad_q    <= bad_nx;
      end
   end
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
   import cga_pkg::*;
#(
   parameter int IN_W   = 10,
   parameter int LOCK_N = 4,
   parameter int LOSS_N = 4,
   localparam int CNT_W = $clog2(LOCK_N + 1),
   localparam int BAD_W = $clog2(LOSS_N + 1)
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            align_en_i,
   input  logic [IN_W-1:0] din_i,
   output logic [9:0]      grp_o,
   output logic            grp_v_o,
   output logic            nsync_o
);
   if (LOCK_N < 2 || LOSS_N < 1) begin : g_bad_counts
      $error("LOCK_N must be at least 2 and LOSS_N at least 1");
   end

   logic [CG_W-1:0]   raw_q, prev_q;
   logic              raw_v, raw_align;
   logic [2*CG_W-1:0] win, shifted;
   logic [CG_W-1:0]   hit, good;
   logic              any_hit;
   logic [OFF_W-1:0]  first_off, trk_off, off_nx;
   logic              trk_locked, lock_nx;
   logic [CNT_W-1:0]  trk_cnt;
   logic [BAD_W-1:0]  trk_bad;
   logic [CG_W-1:0]   grp_q;
   logic              grp_v_q, byp_q;

   cga_gear #(.IN_W(IN_W)) u_gear (
      .clk_i(clk_i), .rst_i(rst_i), .align_en_i(align_en_i), .din_i(din_i),
      .raw_q(raw_q), .raw_v(raw_v), .raw_align(raw_align)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i)      prev_q <= '0;
      else if (raw_v) prev_q <= raw_q;
   end

   assign win = {raw_q, prev_q};

   cga_scan u_scan (
      .win(win), .hit(hit), .good(good), .any_hit(any_hit), .first_off(first_off)
   );

   cga_lock #(.LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_lock (
      .clk_i(clk_i), .rst_i(rst_i), .step(raw_v), .align(raw_align),
      .hit(hit), .good(good), .any_hit(any_hit), .first_off(first_off),
      .locked_q(trk_locked), .off_q(trk_off), .lock_nx(lock_nx), .off_nx(off_nx),
      .cnt_q(trk_cnt), .bad_q(trk_bad)
   );

   assign shifted = win >> off_nx;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         grp_q   <= '0;
         grp_v_q <= 1'b0;
         byp_q   <= 1'b0;
      end else begin
         byp_q   <= raw_v && !raw_align;
         grp_v_q <= raw_v && (!raw_align || lock_nx);
         if (raw_v) grp_q <= raw_align ? shifted[CG_W-1:0] : raw_q;
      end
   end

   assign grp_o   = grp_q;
   assign grp_v_o = grp_v_q;
   assign nsync_o = !trk_locked;
endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk #(
   parameter int LOCK_N = 4,
   parameter int LOSS_N = 4,
   parameter int CNT_W  = 3,
   parameter int BAD_W  = 3
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             grp_v_o,
   input logic             nsync_o,
   input logic             byp_q,
   input logic             raw_v,
   input logic             locked_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [BAD_W-1:0] bad_q
);
   a_r6_fwd_needs_lock: assert property (@(posedge clk_i) disable iff (rst_i)
      (grp_v_o && !byp_q) |-> !nsync_o);

   a_r3_lock_after_count: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(locked_q) |-> ($past(cnt_q) == CNT_W'(LOCK_N - 1)));

   a_r8_loss_after_run: assert property (@(posedge clk_i) disable iff (rst_i)
      ($rose(nsync_o) && !byp_q) |-> (!grp_v_o && $past(bad_q) == BAD_W'(LOSS_N - 1)));

   a_r9_bypass_flags: assert property (@(posedge clk_i) disable iff (rst_i)
      byp_q |-> (grp_v_o && nsync_o));

   a_r11_valid_follows_word: assert property (@(posedge clk_i) disable iff (rst_i)
      grp_v_o |-> $past(raw_v));
endmodule

bind comma_aligner comma_aligner_chk #(
   .LOCK_N(LOCK_N), .LOSS_N(LOSS_N), .CNT_W(CNT_W), .BAD_W(BAD_W)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .grp_v_o(grp_v_o), .nsync_o(nsync_o),
   .byp_q(byp_q), .raw_v(raw_v), .locked_q(trk_locked), .cnt_q(trk_cnt), .bad_q(trk_bad)
);

// File: tb/comma_aligner_tb.sv
`timescale 1ns/1ps
module comma_aligner_tb;
   localparam int MAXW = 640;
   localparam logic [9:0] K_NEG = 10'b0101111100;
   localparam logic [9:0] K_POS = 10'b1010000011;
   localparam logic [9:0] K_BAD = 10'b1101111100;
   localparam logic [9:0] D_A   = 10'b0101010101;
   localparam logic [9:0] D_B   = 10'b0010111001;
   localparam logic [9:0] Z_INV = 10'b0000000000;
   localparam logic [9:0] O_INV = 10'b1111111111;

   logic clk = 1'b0, rst = 1'b1, align_en = 1'b1;
   logic [9:0] din = '0;
   logic [9:0] grp;
   logic grp_v, nsync;
   int total = 0, bad = 0;

   bit bits_q [MAXW*10];
   bit wmode [MAXW];
   int nbits, nw;
   bit cur_mode;
   logic [9:0] wrd [MAXW];
   logic [9:0] exp_g [MAXW];
   bit exp_v [MAXW], exp_ns [MAXW];
   logic [9:0] obs_g [MAXW];
   bit obs_v [MAXW], obs_ns [MAXW];

   always #2 clk = ~clk;

   comma_aligner u_dut (
      .clk_i(clk), .rst_i(rst), .align_en_i(align_en), .din_i(din),
      .grp_o(grp), .grp_v_o(grp_v), .nsync_o(nsync)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic bit g_ok(input logic [9:0] g);
      int n = 0;
      for (int i = 0; i < 10; i++) n += int'(g[i]);
      return (n >= 4) && (n <= 6);
   endfunction

   function automatic bit g_comma(input logic [9:0] g);
      return g_ok(g) && ((g[7:0] == 8'b01111100) || (g[7:0] == 8'b10000011));
   endfunction

   task automatic new_stream(input bit mode);
      nbits = 0;
      cur_mode = mode;
   endtask

   task automatic push_bit(input bit b);
      if (nbits % 10 == 0) wmode[nbits/10] = cur_mode;
      bits_q[nbits] = b;
      nbits++;
   endtask

   task automatic push_grp(input logic [9:0] g);
      for (int i = 0; i < 10; i++) push_bit(g[i]);
   endtask

   task automatic junk(input int n);
      for (int i = 0; i < n; i++) push_bit(i % 2 == 0);
   endtask

   // reference behaviour from the requirements
   task automatic model();
      logic [9:0] prv = '0;
      bit lk = 0;
      int cnt = 0, nbad = 0, off = 0;
      for (int k = 0; k < nw; k++) begin
         logic [19:0] w = {wrd[k], prv};
         if (!wmode[k]) begin
            lk = 0; cnt = 0; nbad = 0; off = 0;
            exp_v[k] = 1; exp_g[k] = wrd[k]; exp_ns[k] = 1;
         end else begin
            int first = -1;
            for (int o = 9; o >= 0; o--) if (g_comma(w[o +: 10])) first = o;
            if (!lk) begin
               if (cnt != 0 && g_comma(w[off +: 10])) begin
                  cnt++;
                  if (cnt == 4) begin lk = 1; cnt = 0; nbad = 0; end
               end else if (first >= 0) begin
                  off = first; cnt = 1;
               end else if (cnt != 0 && !g_ok(w[off +: 10])) begin
                  cnt = 0;
               end
            end else if (!g_ok(w[off +: 10])) begin
               nbad++;
               if (nbad == 4) begin lk = 0; nbad = 0; end
            end else begin
               nbad = 0;
            end
            exp_v[k] = lk; exp_ns[k] = !lk; exp_g[k] = w[off +: 10];
         end
         prv = wrd[k];
      end
   endtask

   task automatic run_stream(input string tag);
      while (nbits % 10 != 0) push_bit(nbits % 2 == 0);
      nw = nbits / 10;
      for (int k = 0; k < nw; k++)
         for (int i = 0; i < 10; i++) wrd[k][i] = bits_q[10*k + i];
      model();
      @(negedge clk);
      rst = 1'b1; din = '0; align_en = 1'b1;
      repeat (3) @(negedge clk);
      chk(grp_v == 1'b0 && nsync == 1'b1, "R1 reset state", {grp_v, nsync}, 2'b01);
      rst = 1'b0;
      for (int j = 0; j < nw + 2; j++) begin
         if (j >= 2) begin
            int k = j - 2;
            obs_v[k] = grp_v; obs_ns[k] = nsync; obs_g[k] = grp;
            chk(grp_v == exp_v[k], {tag, " R11 valid timing"}, grp_v, exp_v[k]);
            chk(nsync == exp_ns[k], {tag, " R6 sync flag"}, nsync, exp_ns[k]);
            if (exp_v[k]) chk(grp == exp_g[k], {tag, " R2 group bits"}, grp, exp_g[k]);
         end
         din = (j < nw) ? wrd[j] : '0;
         align_en = (j < nw) ? wmode[j] : 1'b1;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));

      // R3 / R4: four commas of mixed polarity with data between
      new_stream(1); junk(3);
      push_grp(K_NEG); push_grp(D_A); push_grp(K_POS); push_grp(D_B); push_grp(D_A);
      push_grp(K_NEG); push_grp(K_POS); push_grp(D_A); push_grp(D_B); push_grp(D_A);
      run_stream("R3");
      for (int k = 0; k < 7; k++) chk(obs_v[k] == 0, "R6 no output before lock", obs_v[k], 0);
      chk(obs_ns[6] == 1 && obs_ns[7] == 0, "R3 lock word", {obs_ns[6], obs_ns[7]}, 2'b10);
      chk(obs_v[7] == 1 && obs_g[7] == K_POS, "R3 first group is fourth comma", obs_g[7], K_POS);
      chk(obs_g[8] == D_A, "R4 data after lock", obs_g[8], D_A);

      // R5: offset jump restarts the count
      new_stream(1); junk(2);
      push_grp(K_NEG); push_grp(K_POS); push_grp(K_NEG); junk(4);
      push_grp(K_POS); push_grp(K_NEG); push_grp(K_POS); push_grp(K_NEG);
      push_grp(D_A); push_grp(D_B);
      run_stream("R5");
      chk(obs_ns[6] == 1 && obs_v[6] == 0, "R5 not locked after three at new offset", {obs_ns[6], obs_v[6]}, 2'b10);
      chk(obs_v[7] == 1 && obs_g[7] == K_NEG, "R5 lock at new offset", obs_g[7], K_NEG);

      // R7: bad-weight comma clears the count
      new_stream(1);
      push_grp(K_NEG); push_grp(K_POS); push_grp(K_BAD); push_grp(K_NEG);
      push_grp(K_POS); push_grp(K_NEG); push_grp(D_A); push_grp(K_POS); push_grp(D_B);
      run_stream("R7");
      chk(obs_v[5] == 0 && obs_ns[7] == 1, "R7 count cleared by invalid group", {obs_v[5], obs_ns[7]}, 2'b01);
      chk(obs_v[8] == 1 && obs_g[8] == K_POS, "R4 R7 lock after data hold", obs_g[8], K_POS);

      // R8: three invalid groups keep lock, four drop it
      new_stream(1); junk(5);
      for (int i = 0; i < 4; i++) push_grp(i % 2 ? K_POS : K_NEG);
      push_grp(D_A);
      for (int i = 0; i < 3; i++) push_grp(Z_INV);
      push_grp(D_B);
      for (int i = 0; i < 4; i++) push_grp(Z_INV);
      push_grp(D_A); push_grp(D_B);
      run_stream("R8");
      chk(obs_v[8] == 1 && obs_g[8] == Z_INV, "R8 invalid group forwarded while locked", obs_g[8], Z_INV);
      chk(obs_ns[12] == 0 && obs_v[12] == 1, "R8 three in a row keep lock", {obs_ns[12], obs_v[12]}, 2'b01);
      chk(obs_ns[13] == 1 && obs_v[13] == 0, "R8 fourth drops lock", {obs_ns[13], obs_v[13]}, 2'b10);
      chk(obs_v[14] == 0, "R8 search after loss", obs_v[14], 0);

      // R9: bypass forwards raw words, commas ignored
      new_stream(0); junk(4);
      for (int i = 0; i < 8; i++) push_grp(i % 2 ? K_POS : K_NEG);
      push_grp(D_A);
      run_stream("R9");
      for (int k = 0; k < nw; k++) begin
         chk(obs_v[k] == 1 && obs_ns[k] == 1, "R9 bypass flags", {obs_v[k], obs_ns[k]}, 2'b11);
         chk(obs_g[k] == wrd[k], "R9 bypass raw word", obs_g[k], wrd[k]);
      end

      // R10: bypass word clears lock
      new_stream(1);
      for (int i = 0; i < 4; i++) push_grp(K_NEG);
      push_grp(D_A);
      cur_mode = 0; push_grp(D_B); push_grp(D_A);
      cur_mode = 1;
      push_grp(K_POS); push_grp(K_NEG); push_grp(K_POS); push_grp(K_NEG); push_grp(D_A);
      run_stream("R10");
      chk(obs_ns[5] == 1 && obs_v[5] == 1, "R10 bypass word", {obs_ns[5], obs_v[5]}, 2'b11);
      chk(obs_v[7] == 0 && obs_ns[10] == 1, "R10 lock cleared", {obs_v[7], obs_ns[10]}, 2'b01);
      chk(obs_v[11] == 1 && obs_g[11] == K_NEG, "R10 relock after four", obs_g[11], K_NEG);

      // random mix against the model
      new_stream(1); junk(7);
      for (int i = 0; i < 320; i++) begin
         int r = int'($urandom % 100);
         if (r < 45) push_grp(($urandom % 2) ? D_A : D_B);
         else if (r < 82) push_grp(($urandom % 2) ? K_POS : K_NEG);
         else if (r < 90) push_grp(($urandom % 2) ? O_INV : Z_INV);
         else if (r < 93) push_grp(K_BAD);
         else if (r < 97) junk(int'($urandom % 9) + 1);
         else cur_mode = ($urandom % 4) != 0;
      end
      run_stream("R4 random");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule